// File: doc/BRIEF.md
# Addressable Serial Quad-Channel Converter Front End

This block is the digital front end of a four-channel converter. A host shifts in a 16-bit frame on a serial data line. An active-low frame-sync line frames the transfer, and the data is sampled on falling edges of a serial clock. Two bits in each frame carry a device address. When they equal the two address strap inputs, the 12-bit payload is written into one of four input latches, chosen by two channel-select bits. Each channel has a second register stage, the DAC latch, which drives the outputs. A low level on the load input copies all four input latches into the DAC latches together. A low level on the clear input zeroes the DAC latches.

The most significant shift-register stage is driven out on a chain output. Several devices can share one serial line by daisy-chaining, and each device keeps only the frames that carry its own address. The serial, load and clear pins are asynchronous to the system clock `clk`. They are synchronized before use and sampled at `clk` rate, so the serial clock must stay well below a quarter of `clk`. The pins carry no back-pressure: the block accepts every frame at the rate the host drives it.

Top module: `qdac_serial_if`

## Requirements
- R1: A frame is sent bit 15 first and bit 0 last. Bits 15..4 hold the 12-bit payload, bits 3..2 hold the device address, and bits 1..0 select the channel (0..3). Channel k drives `dac_o[12*k+11 : 12*k]`.
- R2: On the 16th falling serial-clock edge after frame-sync goes low, the payload is written into the selected input latch only, if the address matches.
- R3: A frame whose address bits differ from `dev_addr_i` changes no input latch.
- R4: While load and clear are both high, the DAC outputs hold their values, whatever frames arrive.
- R5: While `load_n_i` is low, all four DAC latches take the contents of their input latches.
- R6: `chain_o` is the oldest stored shift bit. After the 16th edge of a frame, each further edge presents the frame's bits in order, MSB first, whether or not the address matched.
- R7: If frame-sync rises before the 16th edge, nothing is written, and the next frame counts its edges from zero.
- R8: While `clear_n_i` is low, all DAC outputs are zero. Clear leaves the input latches intact, so a later load restores their values.
- R9: When clear and load are low together, clear wins and the DAC outputs stay zero.
- R10: Falling edges after the 16th in the same frame write nothing more.
- R11: After reset, all DAC outputs, all input latches and `chain_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data sampled on its falling edge |
| fsync_n_i | input | 1 | Active-low, level-sensitive frame sync |
| sdata_i | input | 1 | Serial data in, MSB first |
| dev_addr_i | input | 2 | Device address straps |
| load_n_i | input | 1 | Active-low update of all DAC latches |
| clear_n_i | input | 1 | Active-low zeroing of all DAC latches |
| chain_o | output | 1 | Daisy-chain output, MSB stage of the shifter |
| dac_o | output | 48 | Four 12-bit DAC latch values, channel 0 in the low bits |

## Verification
The bench writes a distinct payload to each of the four channels. This shows that the select bits steer each write to a single latch and that the payload bits are not reordered. A frame carrying a foreign address is sent next to matching frames: the mismatched one must change nothing, while its bits still leave through the chain output in order. A 32-bit frame checks that bits after the 16th neither write nor stop the chain output. A truncated frame followed by a full one checks that the edge count restarts. The clear and load tests show clear overriding load and the input latches surviving a clear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int DATA_W = 12;
  parameter int SEL_W  = 2;
  parameter int ADDR_W = 2;
  parameter int SYNC_STAGES = 2;

  function automatic int frame_len(int dw, int aw, int sw);
    return dw + aw + sw;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= INIT;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               fs_n_s,
  input  logic               sdi_s,
  output logic               chain_o,
  output logic               wr_en_o,
  output logic [FRAME_W-1:0] wr_word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_d;
  logic               fall;
  logic [CNT_W-1:0]   edge_cnt;
  logic [FRAME_W-1:0] shreg;

  assign fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  // Edge counter: cleared while the frame is idle, saturates after a full word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_cnt <= '0;
    else if (fs_n_s) edge_cnt <= '0;
    else if (fall && edge_cnt != FULL) edge_cnt <= edge_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (fall && !fs_n_s) shreg <= {shreg[FRAME_W-2:0], sdi_s};
  end

  assign wr_word_o = {shreg[FRAME_W-2:0], sdi_s};
  assign wr_en_o   = fall && !fs_n_s && (edge_cnt == LAST);
  assign chain_o   = shreg[FRAME_W-1];
endmodule

// File: rtl/qdac_latches.sv
module qdac_latches #(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [DATA_W+ADDR_W+SEL_W-1:0]  wr_word_i,
  input  logic [ADDR_W-1:0]               dev_addr_i,
  input  logic                            ld_act_i,
  input  logic                            clr_act_i,
  output logic [(1<<SEL_W)*DATA_W-1:0]    inlat_o,
  output logic [(1<<SEL_W)*DATA_W-1:0]    dac_o
);
  localparam int CH      = 1 << SEL_W;
  localparam int FRAME_W = DATA_W + ADDR_W + SEL_W;

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] payload;
  logic              hit;

  assign sel     = wr_word_i[SEL_W-1:0];
  assign addr    = wr_word_i[SEL_W+ADDR_W-1:SEL_W];
  assign payload = wr_word_i[FRAME_W-1:SEL_W+ADDR_W];
  assign hit     = wr_en_i && (addr == dev_addr_i);

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inlat_o[c*DATA_W +: DATA_W] <= '0;
      else if (hit && sel == SEL_W'(c)) inlat_o[c*DATA_W +: DATA_W] <= payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_o[c*DATA_W +: DATA_W] <= '0;
      else if (clr_act_i) dac_o[c*DATA_W +: DATA_W] <= '0;
      else if (ld_act_i) dac_o[c*DATA_W +: DATA_W] <= inlat_o[c*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int P_DATA_W = qdac_pkg::DATA_W,
  parameter int P_SEL_W  = qdac_pkg::SEL_W,
  parameter int P_ADDR_W = qdac_pkg::ADDR_W,
  parameter int P_SYNC   = qdac_pkg::SYNC_STAGES
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sclk_i,
  input  logic                                 fsync_n_i,
  input  logic                                 sdata_i,
  input  logic [P_ADDR_W-1:0]                  dev_addr_i,
  input  logic                                 load_n_i,
  input  logic                                 clear_n_i,
  output logic                                 chain_o,
  output logic [(1<<P_SEL_W)*P_DATA_W-1:0]     dac_o
);
  localparam int FRAME_W = frame_len(P_DATA_W, P_ADDR_W, P_SEL_W);
  localparam int CH      = 1 << P_SEL_W;

  logic [4:0]                raw_pins, sync_pins;
  logic                      sclk_s, fs_n_s, sdi_s, ld_act, clr_act;
  logic                      wr_en;
  logic [FRAME_W-1:0]        wr_word;
  logic [CH*P_DATA_W-1:0]    inlat;

  assign raw_pins = {sclk_i, fsync_n_i, sdata_i, load_n_i, clear_n_i};

  qdac_sync #(.WIDTH(5), .STAGES(P_SYNC), .INIT(5'b01011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_pins), .q_o(sync_pins)
  );

  assign {sclk_s, fs_n_s, sdi_s} = sync_pins[4:2];
  assign ld_act  = ~sync_pins[1];
  assign clr_act = ~sync_pins[0];

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .fs_n_s(fs_n_s), .sdi_s(sdi_s),
    .chain_o(chain_o), .wr_en_o(wr_en), .wr_word_o(wr_word)
  );

  qdac_latches #(.DATA_W(P_DATA_W), .SEL_W(P_SEL_W), .ADDR_W(P_ADDR_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_word_i(wr_word),
    .dev_addr_i(dev_addr_i), .ld_act_i(ld_act), .clr_act_i(clr_act),
    .inlat_o(inlat), .dac_o(dac_o)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [DATA_W+ADDR_W+SEL_W-1:0]    wr_word,
  input logic [ADDR_W-1:0]                 dev_addr_i,
  input logic                              ld_act,
  input logic                              clr_act,
  input logic [(1<<SEL_W)*DATA_W-1:0]      inlat,
  input logic [(1<<SEL_W)*DATA_W-1:0]      dac_o
);
  localparam int CH = 1 << SEL_W;
  localparam int FW = DATA_W + ADDR_W + SEL_W;

  logic match;
  assign match = wr_word[SEL_W+ADDR_W-1:SEL_W] == dev_addr_i;

  // R3: a frame for another device leaves every input latch unchanged
  p_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !match) |=> $stable(inlat));

  // R2 / R10: without a write strobe the input latches stay put
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(inlat));

  for (genvar c = 0; c < CH; c++) begin : g_chk
    // R2: a matching write lands in the selected channel only
    p_write_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && match && wr_word[SEL_W-1:0] == SEL_W'(c)) |=>
        inlat[c*DATA_W +: DATA_W] == $past(wr_word[FW-1:SEL_W+ADDR_W]));
  end

  // R4: DAC outputs hold while load and clear are inactive
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_act && !clr_act) |=> $stable(dac_o));

  // R5: load copies the input latches
  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_act && !clr_act) |=> dac_o == $past(inlat));

  // R8: clear zeroes the DAC latches
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> dac_o == '0);

  // R9: clear beats a simultaneous load
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && ld_act) |=> dac_o == '0);
endmodule

bind qdac_serial_if qdac_checker #(
  .DATA_W(P_DATA_W), .SEL_W(P_SEL_W), .ADDR_W(P_ADDR_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
  .dev_addr_i(dev_addr_i), .ld_act(ld_act), .clr_act(clr_act),
  .inlat(inlat), .dac_o(dac_o)
);

// File: tb/tb_qdac_serial_if.sv
`timescale 1ns/1ps
module tb_qdac_serial_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, fs_n = 1'b1, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic [1:0]  dev_addr = 2'd1;
  logic        chain;
  logic [47:0] dac;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [11:0] exp_in [4];
  logic [11:0] exp_dac [4];

  always #2 clk = ~clk;

  qdac_serial_if dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_n_i(fs_n), .sdata_i(sdi),
    .dev_addr_i(dev_addr), .load_n_i(ld_n), .clear_n_i(clr_n),
    .chain_o(chain), .dac_o(dac)
  );

  task automatic wait_c(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_dac(string req);
    for (int c = 0; c < 4; c++) check(req, 32'(dac[c*12 +: 12]), 32'(exp_dac[c]));
  endtask

  function automatic logic [15:0] mk(logic [11:0] d, logic [1:0] a, logic [1:0] s);
    return {d, a, s};
  endfunction

  task automatic send_bit(logic b);
    @(negedge clk); sdi = b; sclk = 1'b1;
    wait_c(8);
    sclk = 1'b0;
    wait_c(8);
  endtask

  task automatic send_frame(logic [15:0] w, int nbits);
    fs_n = 1'b0; wait_c(4);
    for (int i = 15; i > 15 - nbits; i--) send_bit(w[i]);
    wait_c(4); fs_n = 1'b1; wait_c(8);
    if (nbits >= 16 && w[3:2] == dev_addr) exp_in[w[1:0]] = w[15:4];
  endtask

  task automatic pulse_load();
    ld_n = 1'b0; wait_c(4); ld_n = 1'b1; wait_c(6);
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
  endtask

  task automatic t_reset();
    check("R11 chain", 32'(chain), 0);
    check_dac("R11 dac");
  endtask

  task automatic t_write_all();
    send_frame(mk(12'hA51, 2'd1, 2'd0), 16);
    send_frame(mk(12'h3C7, 2'd1, 2'd1), 16);
    send_frame(mk(12'hF0E, 2'd1, 2'd2), 16);
    send_frame(mk(12'h812, 2'd1, 2'd3), 16);
    check_dac("R4 hold before load");
    pulse_load();
    check_dac("R1 R2 R5 per-channel write");
  endtask

  task automatic t_mismatch();
    send_frame(mk(12'h777, 2'd2, 2'd0), 16);
    send_frame(mk(12'h111, 2'd0, 2'd2), 16);
    pulse_load();
    check_dac("R3 foreign address ignored");
  endtask

  task automatic t_chain();
    logic [15:0] w1 = mk(12'hB6D, 2'd3, 2'd1);
    logic [15:0] w2 = mk(12'h5A5, 2'd1, 2'd3);
    fs_n = 1'b0; wait_c(4);
    for (int i = 15; i >= 0; i--) send_bit(w1[i]);
    for (int i = 15; i >= 0; i--) begin
      check("R6 chain bit", 32'(chain), 32'(w1[i]));
      send_bit(w2[i]);
    end
    wait_c(4); fs_n = 1'b1; wait_c(8);
    pulse_load();
    check_dac("R10 no write after 16th edge");
  endtask

  task automatic t_abort();
    send_frame(mk(12'h9C3, 2'd1, 2'd2), 10);
    pulse_load();
    check_dac("R7 truncated frame ignored");
    send_frame(mk(12'h246, 2'd1, 2'd2), 16);
    pulse_load();
    check_dac("R7 fresh count after abort");
  endtask

  task automatic t_clear();
    clr_n = 1'b0; wait_c(6);
    for (int c = 0; c < 4; c++) exp_dac[c] = '0;
    check_dac("R8 clear zeroes");
    ld_n = 1'b0; wait_c(6);
    check_dac("R9 clear wins over load");
    ld_n = 1'b1; clr_n = 1'b1; wait_c(6);
    check_dac("R8 zero held after clear");
    pulse_load();
    check_dac("R8 input latches survive clear");
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
    wait_c(5); rst_n = 1'b1; wait_c(5);
    t_reset();
    t_write_all();
    t_mismatch();
    t_chain();
    t_abort();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule